// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block lets clocked logic use an asynchronous byte-wide static RAM with 128K locations. A client offers one request at a time on a valid/ready port. A request carries a direction bit, a 17-bit word address and, for a store, a data byte. The controller then drives the RAM's address lines, its chip-enable pair (one active low, one active high), its active-low output enable and its active-low write enable. It also drives the shared bidirectional data bus in a fixed multi-phase sequence. Every phase is long enough for the RAM's access, pulse-width, setup and bus-release times.

The timing limits are given in nanoseconds as parameters, together with the clock period. Each limit becomes a whole number of cycles, rounded up. A load returns its byte with a one-cycle valid strobe. Between accesses the active-low chip enable is held high, so the RAM drops into its automatic low-power standby.

Top module: `asram_ctrl`

## Requirements
- R1: During reset and after it, the controller is idle: `ram_ce1_n`, `ram_oe_n` and `ram_we_n` are 1, `ram_ce2` is 1, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the cycle after acceptance until the sequence is over, and each accepted request produces exactly one select window (a run of cycles with `ram_ce1_n` at 0).
- R3: For a load (`req_we` = 0), `ram_ce1_n` and `ram_oe_n` are both 0 with `ram_we_n` at 1 for exactly RD cycles, where RD is the larger of the address access time and the output-enable access time, each converted to cycles.
- R4: The byte on `ram_dq` in the last cycle of the load window is returned on `rsp_rdata`, with `rsp_valid` at 1 for exactly one cycle, in the cycle after the window ends.
- R5: For a store (`req_we` = 1), `ram_we_n` is 0 for exactly TURN + WDRV cycles, and `ram_oe_n` stays 1 throughout the select window.
- R6: During a store, the controller leaves `ram_dq` undriven for the first TURN cycles of the write pulse. It then drives the write byte for the last WDRV cycles of the pulse and for one more cycle after `ram_we_n` returns to 1. It never drives while `ram_oe_n` is 0.
- R7: `ram_addr` carries the request address and holds constant for the whole select window. It changes only while `ram_ce1_n` is 1.
- R8: After a load, `req_ready` stays 0 for exactly TURN cycles, counted from the cycle where `rsp_valid` is 1, so that the RAM has released the bus.
- R9: Conversion to cycles rounds up: cycles = ceil(ns / CLK_NS). TURN is the bus-release time in cycles, at least 1. WDRV is the largest of: the data-setup cycles, the write-pulse cycles minus TURN, and the write-cycle cycles minus TURN minus 1.
- R10: `ram_ce2` is held at 1 at all times. The RAM is put into standby only through `ram_ce1_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle; request will be taken |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Store data |
| rsp_valid | output | 1 | One-cycle strobe for load data |
| rsp_rdata | output | DATA_W | Load data |
| ram_addr | output | ADDR_W | RAM address lines |
| ram_dq | inout | DATA_W | Shared RAM data bus |
| ram_ce1_n | output | 1 | Active-low chip enable |
| ram_ce2 | output | 1 | Active-high chip enable |
| ram_oe_n | output | 1 | Active-low output enable |
| ram_we_n | output | 1 | Active-low write enable |

## Verification
The assertions check the following on every cycle:
- output enable and write enable are never low together;
- a write pulse only occurs inside a select window;
- the controller's data drivers never turn on while output enable is low, and turn on only after write enable has already been low for a cycle;
- the address stays fixed inside a select window;
- the load strobe is a single-cycle pulse.

Only the bench scenarios can show the rest: the exact lengths of the load window, the write pulse and the post-load turnaround; that stored bytes really reach the RAM and come back intact at the lowest and highest addresses; and that back-to-back requests each get exactly one window.

// File: rtl/asram_pkg.sv
package asram_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_RD,
      PH_TURN,
      PH_WZ,
      PH_WD,
      PH_WEND
   } phase_t;

   typedef struct packed {
      logic ce1_n;
      logic ce2;
      logic oe_n;
      logic we_n;
      logic drv;
   } pins_t;

   function automatic int ns2cyc(input int ns, input int clk_ns);
      if (ns <= 0) return 0;
      return (ns + clk_ns - 1) / clk_ns;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic pins_t pins_for(input phase_t p);
      pins_t r;
      r = '{ce1_n: 1'b1, ce2: 1'b1, oe_n: 1'b1, we_n: 1'b1, drv: 1'b0};
      case (p)
         PH_RD:   begin r.ce1_n = 1'b0; r.oe_n = 1'b0; end
         PH_WZ:   begin r.ce1_n = 1'b0; r.we_n = 1'b0; end
         PH_WD:   begin r.ce1_n = 1'b0; r.we_n = 1'b0; r.drv = 1'b1; end
         PH_WEND: begin r.drv = 1'b1; end
         default: ;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             zero
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)            cnt_q <= '0;
      else if (load)         cnt_q <= load_val;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/asram_seq.sv
module asram_seq
   import asram_pkg::*;
#(
   parameter int ACC_C  = 6,
   parameter int TURN_C = 2,
   parameter int WDRV_C = 3,
   parameter int CNT_W  = 3
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  req_valid,
   input  logic  req_we,
   output logic  req_ready,
   output logic  accept,
   output logic  capture,
   output pins_t pins
);

   phase_t           ph_q, ph_d;
   logic             tm_load;
   logic [CNT_W-1:0] tm_val;
   logic             tm_zero;

   asram_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tm_load),
      .load_val (tm_val),
      .zero     (tm_zero)
   );

   assign req_ready = (ph_q == PH_IDLE);
   assign accept    = req_valid & req_ready;

   always_comb begin
      ph_d    = ph_q;
      tm_load = 1'b0;
      tm_val  = '0;
      capture = 1'b0;
      case (ph_q)
         PH_IDLE: if (req_valid) begin
            tm_load = 1'b1;
            if (req_we) begin
               ph_d   = PH_WZ;
               tm_val = CNT_W'(TURN_C - 1);
            end else begin
               ph_d   = PH_RD;
               tm_val = CNT_W'(ACC_C - 1);
            end
         end
         PH_RD: if (tm_zero) begin
            capture = 1'b1;
            ph_d    = PH_TURN;
            tm_load = 1'b1;
            tm_val  = CNT_W'(TURN_C - 1);
         end
         PH_TURN: if (tm_zero) ph_d = PH_IDLE;
         PH_WZ: if (tm_zero) begin
            ph_d    = PH_WD;
            tm_load = 1'b1;
            tm_val  = CNT_W'(WDRV_C - 1);
         end
         PH_WD:   if (tm_zero) ph_d = PH_WEND;
         PH_WEND: ph_d = PH_IDLE;
         default: ph_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q <= PH_IDLE;
         pins <= pins_for(PH_IDLE);
      end else begin
         ph_q <= ph_d;
         pins <= pins_for(ph_d);
      end
   end

   // R5
   write_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pins.we_n |-> (pins.oe_n && !pins.ce1_n && pins.ce2));

   // R2
   idle_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (pins.ce1_n && pins.we_n && pins.oe_n));

   // R4
   capture_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      capture |-> (!pins.oe_n && !pins.ce1_n));

endmodule

// File: rtl/asram_dq_port.sv
module asram_dq_port #(
   parameter int ADDR_W = 17,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              capture,
   input  logic [DATA_W-1:0] dq_in,
   input  logic              sel_n,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic              rvalid,
   output logic [DATA_W-1:0] rdata
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (accept) begin
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rvalid <= 1'b0;
         rdata  <= '0;
      end else begin
         rvalid <= capture;
         if (capture) rdata <= dq_in;
      end
   end

   // R7
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_n && $past(!sel_n)) |-> $stable(addr_q));

   // R4
   rvalid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rvalid |=> !rvalid);

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
   import asram_pkg::*;
#(
   parameter int ADDR_W     = 17,
   parameter int DATA_W     = 8,
   parameter int CLK_NS     = 10,
   parameter int T_ACC_NS   = 55,
   parameter int T_OEACC_NS = 20,
   parameter int T_WP_NS    = 45,
   parameter int T_DS_NS    = 25,
   parameter int T_WC_NS    = 55,
   parameter int T_REL_NS   = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_we,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] ram_addr,
   inout  wire  [DATA_W-1:0] ram_dq,
   output logic              ram_ce1_n,
   output logic              ram_ce2,
   output logic              ram_oe_n,
   output logic              ram_we_n
);

   localparam int ACC_C  = imax(1, imax(ns2cyc(T_ACC_NS, CLK_NS), ns2cyc(T_OEACC_NS, CLK_NS)));
   localparam int TURN_C = imax(1, ns2cyc(T_REL_NS, CLK_NS));
   localparam int WDRV_C = imax(1, imax(ns2cyc(T_DS_NS, CLK_NS),
                                   imax(ns2cyc(T_WP_NS, CLK_NS) - TURN_C,
                                        ns2cyc(T_WC_NS, CLK_NS) - TURN_C - 1)));
   localparam int MAX_C  = imax(ACC_C, imax(TURN_C, WDRV_C));
   localparam int CNT_W  = $clog2(MAX_C + 1);

   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("asram_ctrl: widths must be positive");
      end
      if (CLK_NS < 1) begin : g_bad_clk
         $error("asram_ctrl: clock period must be positive");
      end
   endgenerate

   pins_t             pins;
   logic              accept;
   logic              capture;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] dq_in;

   asram_seq #(
      .ACC_C  (ACC_C),
      .TURN_C (TURN_C),
      .WDRV_C (WDRV_C),
      .CNT_W  (CNT_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_we    (req_we),
      .req_ready (req_ready),
      .accept    (accept),
      .capture   (capture),
      .pins      (pins)
   );

   asram_dq_port #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_dq (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .capture   (capture),
      .dq_in     (dq_in),
      .sel_n     (pins.ce1_n),
      .addr_q    (ram_addr),
      .wdata_q   (wdata_q),
      .rvalid    (rsp_valid),
      .rdata     (rsp_rdata)
   );

   genvar b;
   generate
      for (b = 0; b < DATA_W; b++) begin : g_dq
         assign ram_dq[b] = pins.drv ? wdata_q[b] : 1'bz;
      end
   endgenerate

   assign dq_in     = ram_dq;
   assign ram_ce1_n = pins.ce1_n;
   assign ram_ce2   = pins.ce2;
   assign ram_oe_n  = pins.oe_n;
   assign ram_we_n  = pins.we_n;

   // R6
   bus_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pins.drv |-> pins.oe_n);

   // R6
   turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pins.drv) |-> $past(!pins.we_n));

   // R10
   ce2_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pins.ce2);

endmodule

// File: tb/asram_ctrl_bench.sv
module asram_ctrl_bench;

   localparam int CLK_NS = 20;

   function automatic int ceil_c(input int ns);
      return (ns + CLK_NS - 1) / CLK_NS;
   endfunction
   function automatic int mx(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   localparam int E_RD   = mx(ceil_c(55), ceil_c(20));
   localparam int E_TURN = mx(1, ceil_c(20));
   localparam int E_WDRV = mx(ceil_c(25), mx(ceil_c(45) - E_TURN, ceil_c(55) - E_TURN - 1));

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_we = 1'b0;
   logic [16:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        rsp_valid;
   logic [7:0]  rsp_rdata;
   logic [16:0] ram_addr;
   wire  [7:0]  ram_dq;
   logic        ram_ce1_n, ram_ce2, ram_oe_n, ram_we_n;

   always #(CLK_NS/2) clk = ~clk;

   asram_ctrl #(.CLK_NS(CLK_NS)) u_asram_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_ready (req_ready),
      .req_we    (req_we),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata),
      .ram_addr  (ram_addr),
      .ram_dq    (ram_dq),
      .ram_ce1_n (ram_ce1_n),
      .ram_ce2   (ram_ce2),
      .ram_oe_n  (ram_oe_n),
      .ram_we_n  (ram_we_n)
   );

   // RAM model
   logic [7:0] ram_mem [int];
   logic [7:0] ram_rd = '0;
   logic       ram_drv;

   function automatic logic [7:0] dflt(input logic [16:0] a);
      return a[7:0] ^ {1'b0, a[16:10]} ^ 8'h5A;
   endfunction

   assign ram_drv = !ram_ce1_n && ram_ce2 && !ram_oe_n && ram_we_n;
   assign ram_dq  = ram_drv ? ram_rd : 8'bz;

   // Scoreboard state
   int         total = 0;
   int         bad = 0;
   logic [7:0] shadow [int];
   logic [7:0] exp_q [$];
   logic [16:0] cur_addr = '0;
   logic [7:0]  cur_wdata = '0;
   bit         cur_wr = 1'b0;
   int         issued = 0;
   int         windows = 0;
   bit         done = 1'b0;

   task automatic chk(input bit ok, input string rq, input string what,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   task automatic summary;
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   // Driver
   task automatic issue(input bit wr, input logic [16:0] a, input logic [7:0] d);
      req_we    = wr;
      req_addr  = a;
      req_wdata = d;
      req_valid = 1'b1;
      forever begin
         if (req_ready) begin
            cur_wr    = wr;
            cur_addr  = a;
            cur_wdata = d;
            if (wr) shadow[int'(a)] = d;
            else exp_q.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : dflt(a));
            issued++;
            @(negedge clk);
            break;
         end
         @(negedge clk);
      end
      req_valid = 1'b0;
      // R2: busy after acceptance
      chk(req_ready == 1'b0, "R2", "ready after accept", int'(req_ready), 0);
   endtask

   // Monitor
   int  sel_len = 0, we_len = 0, oe_len = 0, drv_bad = 0;
   bit  prev_we_low = 1'b0;
   bit  trk = 1'b0;
   int  tcnt = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         // RAM model: latch on rising write enable, refresh read data
         if (prev_we_low && ram_we_n) ram_mem[int'(ram_addr)] = ram_dq;
         ram_rd = ram_mem.exists(int'(ram_addr)) ? ram_mem[int'(ram_addr)] : dflt(ram_addr);

         if (!ram_ce2) chk(1'b0, "R10", "ce2 low", 0, 1);

         if (!ram_ce1_n) begin
            sel_len++;
            if (ram_addr != cur_addr)
               chk(1'b0, "R7", "address in window", int'(ram_addr), int'(cur_addr));
            if (!ram_oe_n) oe_len++;
            if (!ram_we_n) begin
               we_len++;
               // R6: driven in last WDRV cycles of the pulse
               if (we_len > E_TURN)
                  chk(ram_dq == cur_wdata, "R6", "write data on bus", int'(ram_dq), int'(cur_wdata));
            end
         end else if (sel_len > 0) begin
            windows++;
            if (cur_wr) begin
               chk(we_len == E_TURN + E_WDRV, "R5", "write pulse length", we_len, E_TURN + E_WDRV);
               chk(oe_len == 0, "R5", "oe low in write", oe_len, 0);
               chk(sel_len == E_TURN + E_WDRV, "R9", "write window length", sel_len, E_TURN + E_WDRV);
               // R6: hold cycle after we rises
               chk(ram_dq == cur_wdata, "R6", "data hold after pulse", int'(ram_dq), int'(cur_wdata));
            end else begin
               chk(oe_len == E_RD && sel_len == E_RD && we_len == 0, "R3",
                   "read window length", oe_len, E_RD);
               chk(sel_len == E_RD, "R9", "read window cycles", sel_len, E_RD);
            end
            sel_len = 0; we_len = 0; oe_len = 0;
         end

         // R8 turnaround after a load
         if (trk) begin
            if (!req_ready) tcnt++;
            else begin
               chk(tcnt == E_TURN, "R8", "ready-low after load", tcnt, E_TURN);
               trk = 1'b0;
            end
         end

         if (rsp_valid) begin
            if (exp_q.size() == 0) chk(1'b0, "R4", "unexpected rsp_valid", 1, 0);
            else begin
               logic [7:0] e;
               e = exp_q.pop_front();
               chk(rsp_rdata == e, "R4", "load data", int'(rsp_rdata), int'(e));
            end
            chk(req_ready == 1'b0, "R8", "ready with rsp_valid", int'(req_ready), 0);
            trk = 1'b1;
            tcnt = 1;
         end

         prev_we_low = !ram_we_n;
      end
   end

   // Watchdog
   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc == 100000 && !done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk({ram_ce1_n, ram_oe_n, ram_we_n, ram_ce2} == 4'b1111, "R1", "pins in reset",
          int'({ram_ce1_n, ram_oe_n, ram_we_n, ram_ce2}), 15);
      chk(rsp_valid == 1'b0, "R1", "rsp_valid in reset", int'(rsp_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
      chk(ram_ce1_n == 1'b1, "R1", "deselected after reset", int'(ram_ce1_n), 1);

      // loads of never-written locations, lowest and highest address
      issue(1'b0, 17'h00000, 8'h00);
      issue(1'b0, 17'h1FFFF, 8'h00);
      // stores then loads
      issue(1'b1, 17'h00000, 8'hA5);
      issue(1'b1, 17'h1FFFF, 8'hFF);
      issue(1'b1, 17'h0ABCD, 8'h00);
      issue(1'b0, 17'h00000, 8'h00);
      issue(1'b0, 17'h1FFFF, 8'h00);
      issue(1'b0, 17'h0ABCD, 8'h00);
      // overwrite and read back immediately
      issue(1'b1, 17'h0ABCD, 8'h3C);
      issue(1'b0, 17'h0ABCD, 8'h00);
      // alternating pattern
      for (int i = 0; i < 8; i++) begin
         issue(1'b1, 17'(17'h10000 + i * 17'h111), 8'(8'h11 * i + 8'h01));
         issue(1'b0, 17'(17'h10000 + i * 17'h111), 8'h00);
      end
      // back-to-back loads
      for (int i = 0; i < 4; i++) issue(1'b0, 17'(17'h10000 + i * 17'h111), 8'h00);

      repeat (12) @(negedge clk);
      chk(exp_q.size() == 0, "R4", "pending loads", exp_q.size(), 0);
      chk(windows == issued, "R2", "select windows per request", windows, issued);
      chk(req_ready == 1'b1 && ram_ce1_n == 1'b1, "R10", "standby when idle",
          int'(ram_ce1_n), 1);
      done = 1'b1;
      summary();
      $finish;
   end

endmodule